// File: doc/BRIEF.md
# Buffered Full-Duplex Serial Peripheral Master

This block is a serial peripheral interface master that a processor drives through two register addresses. One address carries data: a write places a byte in a transmit holding buffer and a read returns the last byte received. The other address carries control on write and status on read. The status word reports whether the holding buffer is empty, whether a received byte is waiting, whether the block is busy, whether a received byte was lost, and the current settings.

The serial clock runs only while a transmit byte is available and the block is enabled. Each frame is eight clock periods, most significant bit first. On every period the master drives one outgoing bit and samples one incoming bit, so each byte written produces exactly one byte received. Because the holding buffer sits in front of the shifter, software can queue the next byte while the current one shifts. When it does so before the current frame ends, the next frame follows with no idle clock period. Chip select is not part of this block; software drives it from a general-purpose output.

The register bus has no back-pressure: every access completes in the cycle it is presented. A data write that finds the holding buffer full is dropped, so software must wait for the transmit-empty flag before each write.

Top module: `spi_buffered_master`

## Requirements
- R1: Address 0 is the data register: a write loads the transmit holding buffer and a read returns the receive buffer. Address 1 is control on write (bit 0 enable, bits 3:1 divider exponent D) and status on read (bit 0 transmit-empty TXE, bit 1 receive-full RXNE, bit 2 busy BSY, bit 3 overrun OVR, bit 4 enable, bits 7:5 D).
- R2: After reset the status reads TXE=1, RXNE=0, BSY=0, OVR=0, enable=0, D=0, and the serial clock is low.
- R3: A data write clears TXE. When the shifter is idle and the block is enabled, the byte moves into the shifter on the next clock edge and TXE is set again.
- R4: With enable clear, a written byte stays pending with BSY=1 and no serial clock edge occurs.
- R5: A frame is 8 serial clock periods, each half-period 2^D system clocks, with the clock idle low. The outgoing line changes only on falling edges, the incoming line is sampled on rising edges, and bits go most significant first.
- R6: RXNE is set when a complete frame lands in the receive buffer, and a data read clears it.
- R7: BSY is high while a frame shifts or a byte is pending, and low otherwise.
- R8: When the holding buffer is refilled before the current frame ends, the next frame starts with no idle serial clock: the rising edges stay evenly spaced at 2^(D+1) system clocks.
- R9: A frame that completes while RXNE is set overwrites the receive buffer and sets OVR. OVR clears only when a status read reporting it is followed by a data read; a data read alone leaves it set.
- R10: A data write while the holding buffer is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register address: 0 data, 1 control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong fill state of the holding buffer shows as a missing or duplicated frame on the serial lines, or a TXE reading that is off by one access around the write. A bad bit counter or divider shows within one frame as a byte captured by the bench slave that differs from the one written, or as a rise-to-rise spacing that breaks in a back-to-back burst. A mishandled receive flag shows at the next status read, and a mishandled overrun shows at the first data read after two unread frames.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int ST_TXE  = 0;
  localparam int ST_RXNE = 1;
  localparam int ST_BSY  = 2;
  localparam int ST_OVR  = 3;
  localparam int ST_EN   = 4;
  localparam int ST_DIV  = 5;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_exp,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = (CNT_W'(1) << div_exp) - CNT_W'(1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              pend,
  input  logic [DATA_W-1:0] pend_data,
  output logic              take,
  output logic              active,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              frame_done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int BIT_W = $clog2(DATA_W);

  logic              active_q;
  logic              sck_q;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              last_bit;
  logic              fall_now;
  logic              can_load;

  assign last_bit   = (bit_cnt == BIT_W'(DATA_W - 1));
  assign fall_now   = active_q && tick && sck_q;
  assign can_load   = en && pend;
  assign frame_done = fall_now && last_bit;
  assign take       = (!active_q && can_load) || (frame_done && can_load);
  assign active     = active_q;
  assign sck        = sck_q;
  assign mosi       = tx_sh[DATA_W-1];
  assign rx_byte    = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      bit_cnt  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (!active_q) begin
      if (can_load) begin
        active_q <= 1'b1;
        tx_sh    <= pend_data;
        bit_cnt  <= '0;
        sck_q    <= 1'b0;
      end
    end else if (tick) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_sh <= {rx_sh[DATA_W-2:0], miso};
      end else begin
        sck_q <= 1'b0;
        if (last_bit) begin
          bit_cnt <= '0;
          if (can_load) tx_sh    <= pend_data;
          else          active_q <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + BIT_W'(1);
          tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_buffered_master.sv
module spi_buffered_master
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int STAT_W = ST_DIV + DIV_W;

  logic              tx_full;
  logic [DATA_W-1:0] tx_buf;
  logic [DATA_W-1:0] rx_buf;
  logic              rxne_q;
  logic              ovr_q;
  logic              ovr_armed;
  logic              en_q;
  logic [DIV_W-1:0]  div_q;
  logic              data_wr, data_rd, stat_rd, ctrl_wr;
  logic              take, eng_active, tick, frame_done, busy;
  logic [DATA_W-1:0] rx_byte;
  logic [STAT_W-1:0] status;

  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
  assign data_rd = bus_rd && (bus_addr == ADDR_DATA);
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign stat_rd = bus_rd && (bus_addr == ADDR_CTRL);
  assign busy    = eng_active || tx_full;

  spi_rate_gen #(.DIV_W(DIV_W)) i_rate (
    .clk(clk), .rst_n(rst_n), .run(eng_active), .div_exp(div_q), .tick(tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) i_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q),
    .pend(tx_full), .pend_data(tx_buf), .take(take), .active(eng_active),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso),
    .frame_done(frame_done), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else if (ctrl_wr) begin
      en_q  <= bus_wdata[0];
      div_q <= bus_wdata[DIV_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
    end else if (data_wr && !tx_full) begin
      tx_full <= 1'b1;
      tx_buf  <= bus_wdata;
    end else if (take) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0;
      rxne_q <= 1'b0;
    end else if (frame_done) begin
      rx_buf <= rx_byte;
      rxne_q <= 1'b1;
    end else if (data_rd) begin
      rxne_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q     <= 1'b0;
      ovr_armed <= 1'b0;
    end else if (frame_done && rxne_q && !data_rd) begin
      ovr_q     <= 1'b1;
      ovr_armed <= 1'b0;
    end else if (data_rd && ovr_armed) begin
      ovr_q     <= 1'b0;
      ovr_armed <= 1'b0;
    end else if (stat_rd && ovr_q) begin
      ovr_armed <= 1'b1;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_TXE] = !tx_full;
    status[ST_RXNE] = rxne_q;
    status[ST_BSY] = busy;
    status[ST_OVR] = ovr_q;
    status[ST_EN]  = en_q;
    status[ST_DIV +: DIV_W] = div_q;
  end

  assign bus_rdata = (bus_addr == ADDR_DATA) ? rx_buf : DATA_W'(status);
endmodule

// File: rtl/spi_buffered_master_chk.sv
module spi_buffered_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic mosi,
  input logic en,
  input logic active,
  input logic tx_full,
  input logic rxne,
  input logic ovr,
  input logic frame_done,
  input logic data_wr,
  input logic data_rd
);
  // R3: an accepted write fills the holding buffer
  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !tx_full) |=> tx_full);

  // R4: no frame starts while disabled
  a_r4_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !active) |=> !active);

  // R5: clock idles low
  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);

  // R5: outgoing bit holds while the clock stays high
  a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R6: completed frame raises the receive flag
  a_r6_done_sets_rxne: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rxne);

  // R6: data read clears the receive flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !frame_done) |=> !rxne);

  // R9: frame landing on an unread byte flags overrun
  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rxne && !data_rd) |=> ovr);
endmodule

bind spi_buffered_master spi_buffered_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sck(spi_sck), .mosi(spi_mosi),
  .en(en_q), .active(eng_active), .tx_full(tx_full), .rxne(rxne_q),
  .ovr(ovr_q), .frame_done(frame_done), .data_wr(data_wr), .data_rd(data_rd)
);

// File: tb/test_spi_buffered_master.sv
module test_spi_buffered_master;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_mosi, spi_miso;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(PERIOD/2) clk = ~clk;

  spi_buffered_master i_spi_buffered_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] slave_byte(int k);
    return 8'((k * 53) ^ 8'hA5);
  endfunction

  function automatic longint span_units(int nbytes, int d);
    return longint'(8 * nbytes - 1) * 2 * (1 << d) * PERIOD;
  endfunction

  // slave model: samples on rising edge, advances its output bit after it
  int         s_idx = 0;
  int         s_frame = 0;
  logic [7:0] s_rx = '0;
  logic [7:0] mosi_log [0:255];
  logic [7:0] s_cur;
  int         rise_count = 0;
  bit         arm_first = 0;
  longint     rise_first = 0, rise_last = 0;

  assign s_cur    = slave_byte(s_frame);
  assign spi_miso = s_cur[3'(7 - s_idx)];

  always @(posedge spi_sck) begin
    s_rx = {s_rx[6:0], spi_mosi};
    rise_count++;
    if (arm_first) begin rise_first = $time; arm_first = 0; end
    rise_last = $time;
    if (s_idx == 7) begin
      mosi_log[s_frame[7:0]] = s_rx;
      s_frame++;
      s_idx = 0;
    end else s_idx++;
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wait_rxne();
    logic [7:0] st;
    for (int i = 0; i < 5000; i++) begin
      bus_read(1'b1, st);
      if (st[1]) break;
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] st, rd, b;
    int ef;
    int sent, got, d;
    void'($urandom(32'd4711));
    ef = 0;

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: reset state
    bus_read(1'b1, st);
    chk(st == 8'h01, "R2 status after reset", st, 8'h01);
    chk(spi_sck == 1'b0, "R2 sck low", spi_sck, 0);

    // R4: disabled, byte stays pending; R10: second write dropped
    bus_write(1'b0, 8'h3C);
    bus_write(1'b0, 8'h99);
    repeat (50) @(posedge clk);
    chk(rise_count == 0, "R4 no clock while disabled", rise_count, 0);
    bus_read(1'b1, st);
    chk(st[2:0] == 3'b100, "R4 R7 pending with BSY, TXE clear", st[2:0], 3'b100);

    bus_write(1'b1, 8'h01);
    wait_rxne();
    bus_read(1'b1, st);
    chk(st[1] == 1'b1, "R6 RXNE set after frame", st[1], 1);
    bus_read(1'b0, rd);
    chk(rd == slave_byte(0), "R1 R5 received byte", rd, slave_byte(0));
    chk(mosi_log[0] == 8'h3C, "R5 sent byte MSB first", mosi_log[0], 8'h3C);
    bus_read(1'b1, st);
    chk(st[1] == 1'b0, "R6 RXNE cleared by read", st[1], 0);
    repeat (40) @(posedge clk);
    chk(s_frame == 1, "R10 write while full ignored", s_frame, 1);
    bus_read(1'b1, st);
    chk(st[2] == 1'b0, "R7 BSY low when idle", st[2], 0);
    chk(spi_sck == 1'b0, "R5 sck idle low", spi_sck, 0);
    ef = 1;

    // R3: TXE clear right after write, set one edge later
    bus_write(1'b0, 8'hE1);
    bus_read(1'b1, st);
    chk(st[0] == 1'b0, "R3 TXE clear after write", st[0], 0);
    bus_read(1'b1, st);
    chk(st[0] == 1'b1 && st[2] == 1'b1, "R3 R7 TXE set, BSY while shifting",
        st[2:0], 3'b101);
    wait_rxne();
    bus_read(1'b0, rd);
    chk(rd == slave_byte(ef), "R5 received byte", rd, slave_byte(ef));
    chk(mosi_log[ef[7:0]] == 8'hE1, "R5 sent byte", mosi_log[ef[7:0]], 8'hE1);
    ef++;

    // R5: half period at D=2
    bus_write(1'b1, 8'h05);
    bus_read(1'b1, st);
    chk(st[7:4] == 4'b0101, "R1 status shows enable and divider", st[7:4], 4'b0101);
    arm_first = 1;
    bus_write(1'b0, 8'h5A);
    wait_rxne();
    bus_read(1'b0, rd);
    chk(rise_last - rise_first == span_units(1, 2), "R5 frame timing D=2",
        rise_last - rise_first, span_units(1, 2));
    chk(mosi_log[ef[7:0]] == 8'h5A, "R5 sent byte D=2", mosi_log[ef[7:0]], 8'h5A);
    ef++;

    // R8: back-to-back burst at D=1
    bus_write(1'b1, 8'h03);
    arm_first = 1;
    sent = 0; got = 0;
    for (int i = 0; i < 4000 && got < 6; i++) begin
      bus_read(1'b1, st);
      if (st[0] && sent < 6) begin
        bus_write(1'b0, 8'(8'h10 + sent));
        sent++;
      end else if (st[1]) begin
        bus_read(1'b0, rd);
        chk(rd == slave_byte(ef + got), "R8 burst received", rd, slave_byte(ef + got));
        chk(mosi_log[8'(ef + got)] == 8'(8'h10 + got), "R8 burst sent",
            mosi_log[8'(ef + got)], 8'(8'h10 + got));
        got++;
      end
    end
    chk(rise_last - rise_first == span_units(6, 1), "R8 no idle clock in burst",
        rise_last - rise_first, span_units(6, 1));
    ef += 6;

    // R9: overrun
    bus_write(1'b1, 8'h01);
    bus_write(1'b0, 8'hA0);
    repeat (40) @(posedge clk);
    bus_write(1'b0, 8'hA1);
    repeat (40) @(posedge clk);
    bus_read(1'b0, rd);
    chk(rd == slave_byte(ef + 1), "R9 receive buffer overwritten", rd, slave_byte(ef + 1));
    bus_read(1'b1, st);
    chk(st[3] == 1'b1, "R9 OVR kept after bare data read", st[3], 1);
    bus_read(1'b0, rd);
    bus_read(1'b1, st);
    chk(st[3] == 1'b0, "R9 OVR cleared by status then data read", st[3], 0);
    ef += 2;

    // random frames across dividers
    for (int n = 0; n < 24; n++) begin
      d = $urandom % 3;
      b = 8'($urandom);
      bus_write(1'b1, 8'((d << 1) | 1));
      bus_write(1'b0, b);
      repeat ($urandom % 5) @(posedge clk);
      wait_rxne();
      bus_read(1'b0, rd);
      chk(rd == slave_byte(ef), "R5 R6 random received", rd, slave_byte(ef));
      chk(mosi_log[ef[7:0]] == b, "R5 random sent", mosi_log[ef[7:0]], b);
      ef++;
    end
    repeat (200) @(posedge clk);
    chk(s_frame == ef, "R10 frame count", s_frame, ef);

    finish_run();
  end
endmodule